// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Interface

This block is the digital front end of a precision two-channel digital-to-analog converter. A host sends 24-bit command words over a three-wire serial port made of an active-low frame select, a serial clock and a data line. Each accepted word writes one of three register kinds. The first is a per-channel input code. The second is a per-channel output-range code. The third is a shared power-control word. The contents of these registers go straight to the analog core.

Input codes do not reach the converter until a load strobe copies them into the DAC registers. A clear input forces the DAC registers to a zero-volt code, and a coding-select pin sets that code. The serial output has two roles. In daisy-chain use it carries the shift register onward. In readback it returns a register that was named in the frame before.

The serial pins are oversampled by the system clock. Each level of the serial clock and of the frame select must therefore last at least two system clock periods. The channel count and the code resolution are parameters. A code narrower than 16 bits is taken from the top of the 16-bit data field.

Top module: `dac_serial_regs`

## Requirements
- R1: A frame is shifted in MSB first, one bit on each falling edge of `ser_clk` while `ser_sel_n` is low. The last 24 bits are decoded as read flag (bit 23), reserved (bit 22), register select (bits 21:19), channel address (bits 18:16) and data (bits 15:0).
- R2: Register select 000 writes the input register of the addressed channel with data bits 15 down to 16-RES_W. Address values 0 to NUM_CH-1 select one channel, address 100 selects every channel, and any other address writes nothing.
- R3: Register select 001 writes data bits 2:0 into the range code of the addressed channel or channels. Select 010 writes data bits NUM_CH-1:0 into `ch_power`, where bit i high powers up channel i and the address is ignored. Select 011 and all other selects write nothing.
- R4: After reset all input and DAC registers are 0, every range code is 000 (5 V unipolar), every channel is powered down, and `ser_dout` is 0.
- R5: When `ser_sel_n` rises, the frame is decoded only if a non-zero multiple of 24 falling edges was received and the reserved bit is 0. Any other frame changes no register.
- R6: While `load_n` is sampled low (and `clear_n` high), each clock edge copies every input register into its DAC register. Otherwise `dac_code` holds, even when the input registers change.
- R7: While `clear_n` is sampled low, every DAC register is set to the clear code: only the MSB set when `coding_sel` is 1 (offset binary), all zeros when `coding_sel` is 0 (two's complement). Clear wins over load and leaves the input registers untouched.
- R8: At the start of a frame, `ser_dout` shows the shift register MSB, and it moves to the new MSB on each rising edge of `ser_clk`. A bit shifted in therefore reaches a downstream device on the 25th falling edge after it entered.
- R9: An accepted frame with the read flag set writes nothing. During the next frame, `ser_dout` shifts out {8'h00, value} MSB first. The value is a left-aligned input code (select 000), a zero-extended range code (001) or the power word (010), and 0 for any other select. Address 100 reads channel 0.
- R10: Serial clock edges while `ser_sel_n` is high neither shift the register nor change `ser_dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, idles high |
| ser_sel_n | input | 1 | Frame select, active low |
| ser_din | input | 1 | Serial data in |
| ser_dout | output | 1 | Serial data out (daisy chain or readback) |
| load_n | input | 1 | Load strobe, active low |
| clear_n | input | 1 | Clear input, active low |
| coding_sel | input | 1 | 1 selects offset binary, 0 selects two's complement |
| dac_code | output | NUM_CH*RES_W | DAC register contents, channel 0 in the low bits |
| out_range | output | NUM_CH*3 | Range code per channel |
| ch_power | output | NUM_CH | Power-up flag per channel |

## Verification
The bench builds the block with two channels and a 14-bit code. This makes the two lowest data bits fall outside the input code, so the left alignment is tested both on writes and on readback. It also lets the address 100 broadcast and an unused address (101) be tried against a real channel pair. The range and power fields share those low data bits, so a decode that mixes up the fields shows up at the outputs.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int FRAME_W   = 24;
  localparam int PAYLOAD_W = 16;
  localparam int RNG_W     = 3;
  localparam int CNT_W     = $clog2(FRAME_W);

  localparam logic [2:0] SEL_INPUT = 3'b000;
  localparam logic [2:0] SEL_RANGE = 3'b001;
  localparam logic [2:0] SEL_POWER = 3'b010;
  localparam logic [2:0] ADDR_ALL  = 3'b100;

  typedef struct packed {
    logic                 rd;
    logic                 rsvd;
    logic [2:0]           sel;
    logic [2:0]           addr;
    logic [PAYLOAD_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/dsr_serial.sv
module dsr_serial
  import dsr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_clk,
  input  logic                 ser_sel_n,
  input  logic                 ser_din,
  input  logic [PAYLOAD_W-1:0] rb_data,
  output frame_t               frame_o,
  output logic                 frame_vld_o,
  output logic                 ser_dout
);
  logic                 sclk_q, sel_q;
  frame_t               sr_q, sr_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 any_q, any_d;
  logic                 vld_q, vld_d;
  logic [PAYLOAD_W-1:0] rb_q, rb_d;
  logic                 pend_q, pend_d;
  logic                 sdo_q, sdo_d;
  logic                 fall, rise, start, stop;

  assign fall  = sclk_q & ~ser_clk & ~ser_sel_n;
  assign rise  = ~sclk_q & ser_clk & ~ser_sel_n;
  assign start = sel_q & ~ser_sel_n;
  assign stop  = ~sel_q & ser_sel_n;

  always_comb begin
    sr_d   = sr_q;
    cnt_d  = cnt_q;
    any_d  = any_q;
    sdo_d  = sdo_q;
    rb_d   = rb_q;
    pend_d = pend_q;
    vld_d  = stop & any_q & (cnt_q == '0);
    if (start) begin
      cnt_d = '0;
      any_d = 1'b0;
      if (pend_q) begin
        sr_d   = frame_t'({{(FRAME_W-PAYLOAD_W){1'b0}}, rb_q});
        pend_d = 1'b0;
      end
      sdo_d = sr_d[FRAME_W-1];
    end else if (fall) begin
      sr_d  = frame_t'({sr_q[FRAME_W-2:0], ser_din});
      cnt_d = (cnt_q == CNT_W'(FRAME_W-1)) ? '0 : cnt_q + 1'b1;
      any_d = 1'b1;
    end else if (rise) begin
      sdo_d = sr_q[FRAME_W-1];
    end
    if (vld_q && sr_q.rd && !sr_q.rsvd) begin
      rb_d   = rb_data;
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      sel_q  <= 1'b1;
      sr_q   <= '0;
      cnt_q  <= '0;
      any_q  <= 1'b0;
      vld_q  <= 1'b0;
      rb_q   <= '0;
      pend_q <= 1'b0;
      sdo_q  <= 1'b0;
    end else begin
      sclk_q <= ser_clk;
      sel_q  <= ser_sel_n;
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
      any_q  <= any_d;
      vld_q  <= vld_d;
      rb_q   <= rb_d;
      pend_q <= pend_d;
      sdo_q  <= sdo_d;
    end
  end

  assign frame_o     = sr_q;
  assign frame_vld_o = vld_q;
  assign ser_dout    = sdo_q;

  // R10: with the frame deselected the shift register is frozen
  a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ser_sel_n |=> $stable(sr_q));
  // R10: no output change while deselected
  a_r10_sdo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ser_sel_n |=> $stable(sdo_q));
  // R5: bit counter stays inside one frame length
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(FRAME_W));
  // R5: an accepted frame is reported for a single cycle
  a_r5_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);
endmodule

// File: rtl/dsr_regs.sv
module dsr_regs
  import dsr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int RES_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  frame_t                  frame_i,
  input  logic                    frame_vld_i,
  output logic [NUM_CH*RES_W-1:0] in_flat,
  output logic [NUM_CH*RNG_W-1:0] rng_flat,
  output logic [NUM_CH-1:0]       pwr,
  output logic [PAYLOAD_W-1:0]    rb_data
);
  logic              wr_ok;
  logic [NUM_CH-1:0] pwr_q, pwr_d;
  logic [2:0]        rd_ch;

  assign wr_ok = frame_vld_i & ~frame_i.rd & ~frame_i.rsvd;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic             hit;
    logic [RES_W-1:0] in_q, in_d;
    logic [RNG_W-1:0] rng_q, rng_d;

    assign hit = (frame_i.addr == 3'(c)) || (frame_i.addr == ADDR_ALL);

    always_comb begin
      in_d  = in_q;
      rng_d = rng_q;
      if (wr_ok && hit) begin
        if (frame_i.sel == SEL_INPUT) in_d  = frame_i.data[PAYLOAD_W-1 -: RES_W];
        if (frame_i.sel == SEL_RANGE) rng_d = frame_i.data[RNG_W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_q  <= '0;
        rng_q <= '0;
      end else begin
        in_q  <= in_d;
        rng_q <= rng_d;
      end
    end

    assign in_flat[c*RES_W +: RES_W]  = in_q;
    assign rng_flat[c*RNG_W +: RNG_W] = rng_q;
  end

  always_comb begin
    pwr_d = pwr_q;
    if (wr_ok && frame_i.sel == SEL_POWER) pwr_d = frame_i.data[NUM_CH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_q <= '0;
    else        pwr_q <= pwr_d;
  end

  assign pwr = pwr_q;

  assign rd_ch = (frame_i.addr == ADDR_ALL) ? 3'd0 : frame_i.addr;

  always_comb begin
    rb_data = '0;
    if (frame_i.sel == SEL_POWER) begin
      rb_data = PAYLOAD_W'(pwr_q);
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (rd_ch == 3'(c)) begin
          if (frame_i.sel == SEL_INPUT)
            rb_data = PAYLOAD_W'(in_flat[c*RES_W +: RES_W]) << (PAYLOAD_W - RES_W);
          else if (frame_i.sel == SEL_RANGE)
            rb_data = PAYLOAD_W'(rng_flat[c*RNG_W +: RNG_W]);
        end
      end
    end
  end

  // R9: a read frame leaves every register as it was
  a_r9_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld_i && frame_i.rd) |=> ($stable(in_flat) && $stable(rng_flat) && $stable(pwr_q)));
  // R5: a frame with the reserved bit set is dropped
  a_r5_rsvd_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld_i && frame_i.rsvd) |=> ($stable(in_flat) && $stable(rng_flat) && $stable(pwr_q)));
  // R2: unused channel addresses write no input register
  a_r2_bad_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld_i && frame_i.addr != ADDR_ALL && frame_i.addr >= 3'(NUM_CH))
      |=> ($stable(in_flat) && $stable(rng_flat)));
endmodule

// File: rtl/dsr_dacreg.sv
module dsr_dacreg #(
  parameter int NUM_CH = 2,
  parameter int RES_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_n,
  input  logic                    clear_n,
  input  logic                    coding_sel,
  input  logic [NUM_CH*RES_W-1:0] in_flat,
  output logic [NUM_CH*RES_W-1:0] dac_flat
);
  logic [RES_W-1:0] clr_code;

  assign clr_code = coding_sel ? {1'b1, {(RES_W-1){1'b0}}} : '0;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [RES_W-1:0] dac_q, dac_d;

    always_comb begin
      dac_d = dac_q;
      if (!clear_n)     dac_d = clr_code;
      else if (!load_n) dac_d = in_flat[c*RES_W +: RES_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dac_q <= '0;
      else        dac_q <= dac_d;
    end

    assign dac_flat[c*RES_W +: RES_W] = dac_q;
  end

  // R7: clear drives every channel to the clear code
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |=> (dac_flat == {NUM_CH{$past(clr_code)}}));
  // R6: load copies the input registers
  a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && !load_n) |=> (dac_flat == $past(in_flat)));
  // R6: without load or clear the DAC registers hold
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && load_n) |=> $stable(dac_flat));
endmodule

// File: rtl/dac_serial_regs.sv
module dac_serial_regs
  import dsr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int RES_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ser_clk,
  input  logic                    ser_sel_n,
  input  logic                    ser_din,
  output logic                    ser_dout,
  input  logic                    load_n,
  input  logic                    clear_n,
  input  logic                    coding_sel,
  output logic [NUM_CH*RES_W-1:0] dac_code,
  output logic [NUM_CH*RNG_W-1:0] out_range,
  output logic [NUM_CH-1:0]       ch_power
);
  frame_t                  frame;
  logic                    frame_vld;
  logic [PAYLOAD_W-1:0]    rb_data;
  logic [NUM_CH*RES_W-1:0] in_flat;

  dsr_serial i_serial (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_clk     (ser_clk),
    .ser_sel_n   (ser_sel_n),
    .ser_din     (ser_din),
    .rb_data     (rb_data),
    .frame_o     (frame),
    .frame_vld_o (frame_vld),
    .ser_dout    (ser_dout)
  );

  dsr_regs #(.NUM_CH(NUM_CH), .RES_W(RES_W)) i_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_i     (frame),
    .frame_vld_i (frame_vld),
    .in_flat     (in_flat),
    .rng_flat    (out_range),
    .pwr         (ch_power),
    .rb_data     (rb_data)
  );

  dsr_dacreg #(.NUM_CH(NUM_CH), .RES_W(RES_W)) i_dacreg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_n     (load_n),
    .clear_n    (clear_n),
    .coding_sel (coding_sel),
    .in_flat    (in_flat),
    .dac_flat   (dac_code)
  );
endmodule

// File: tb/test_dac_serial_regs.sv
module test_dac_serial_regs;
  localparam int NCH = 2;
  localparam int RW  = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b1;
  logic ser_sel_n = 1'b1;
  logic ser_din = 1'b0;
  logic load_n = 1'b1;
  logic clear_n = 1'b1;
  logic coding_sel = 1'b1;
  logic ser_dout;
  logic [NCH*RW-1:0] dac_code;
  logic [NCH*3-1:0]  out_range;
  logic [NCH-1:0]    ch_power;

  always #4 clk = ~clk;

  dac_serial_regs #(.NUM_CH(NCH), .RES_W(RW)) i_dac_serial_regs (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n),
    .ser_din(ser_din), .ser_dout(ser_dout), .load_n(load_n), .clear_n(clear_n),
    .coding_sel(coding_sel), .dac_code(dac_code), .out_range(out_range),
    .ch_power(ch_power)
  );

  int n_chk = 0;
  int n_err = 0;
  bit cmp_on = 1'b0;

  int m_in[NCH];
  int m_dac[NCH];
  int m_rng[NCH];
  int m_pwr;
  logic [23:0] m_sr;
  logic [23:0] m_rb;
  bit   m_pend;
  logic m_sdo;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the behavioural model
  always @(negedge clk) begin
    if (cmp_on) begin
      for (int c = 0; c < NCH; c++) begin
        chk("R6 dac state", 32'(dac_code[c*RW +: RW]), 32'(m_dac[c]));
        chk("R3 range state", 32'(out_range[c*3 +: 3]), 32'(m_rng[c]));
      end
      chk("R3 power state", 32'(ch_power), 32'(m_pwr));
    end
  end

  function automatic logic [15:0] rb_val(logic [2:0] sel, logic [2:0] addr);
    int c = (addr == 3'd4) ? 0 : int'(addr);
    if (sel == 3'b010) return 16'(m_pwr);
    if (c >= NCH) return 16'h0;
    if (sel == 3'b000) return 16'(m_in[c] << (16 - RW));
    if (sel == 3'b001) return 16'(m_rng[c]);
    return 16'h0;
  endfunction

  task automatic apply(logic [23:0] w);
    if (w[22]) return;
    if (w[23]) begin
      m_rb   = {8'h00, rb_val(w[21:19], w[18:16])};
      m_pend = 1'b1;
      return;
    end
    for (int c = 0; c < NCH; c++) begin
      if (w[18:16] == 3'(c) || w[18:16] == 3'd4) begin
        if (w[21:19] == 3'b000) m_in[c]  = int'(w[15 -: RW]);
        if (w[21:19] == 3'b001) m_rng[c] = int'(w[2:0]);
      end
    end
    if (w[21:19] == 3'b010) m_pwr = int'(w[NCH-1:0]);
  endtask

  task automatic frame(logic [47:0] bits, int n, string tag, output logic [47:0] cap);
    cap = '0;
    @(negedge clk);
    ser_sel_n = 1'b0;
    if (m_pend) begin
      m_sr   = m_rb;
      m_pend = 1'b0;
    end
    m_sdo = m_sr[23];
    repeat (2) @(negedge clk);
    for (int k = n - 1; k >= 0; k--) begin
      chk(tag, 32'(ser_dout), 32'(m_sdo));
      cap = {cap[46:0], ser_dout};
      ser_din = bits[k];
      ser_clk = 1'b0;
      m_sr = {m_sr[22:0], bits[k]};
      repeat (2) @(negedge clk);
      ser_clk = 1'b1;
      m_sdo = m_sr[23];
      repeat (2) @(negedge clk);
    end
    ser_sel_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    if (n > 0 && n % 24 == 0) apply(m_sr);
    @(negedge clk);
  endtask

  task automatic w24(logic [23:0] w, string tag);
    logic [47:0] cap;
    frame({24'h0, w}, 24, tag, cap);
  endtask

  task automatic pulse(bit do_load, bit do_clear);
    @(negedge clk);
    load_n  = !do_load;
    clear_n = !do_clear;
    @(posedge clk);
    for (int c = 0; c < NCH; c++) begin
      if (do_clear) m_dac[c] = coding_sel ? (1 << (RW - 1)) : 0;
      else if (do_load) m_dac[c] = m_in[c];
    end
    @(negedge clk);
    load_n  = 1'b1;
    clear_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [47:0] cap;
    logic [23:0] prev;
    for (int c = 0; c < NCH; c++) begin
      m_in[c] = 0; m_dac[c] = 0; m_rng[c] = 0;
    end
    m_pwr = 0; m_sr = '0; m_rb = '0; m_pend = 1'b0; m_sdo = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_on = 1'b1;

    // R4 reset state
    chk("R4 dac after reset", 32'(dac_code), 32'h0);
    chk("R4 range after reset", 32'(out_range), 32'h0);
    chk("R4 power after reset", 32'(ch_power), 32'h0);
    chk("R4 sdo after reset", 32'(ser_dout), 32'h0);

    // R1 R2 single-channel input write, left-aligned, held until load
    w24(24'h00_1234, "R8 sdo");
    chk("R6 no load yet", 32'(dac_code[0 +: RW]), 32'h0);
    pulse(1, 0);
    chk("R1 R2 ch0 code", 32'(dac_code[0 +: RW]), 32'h048D);

    // R2 broadcast address
    w24(24'h04_FFFC, "R8 sdo");
    pulse(1, 0);
    chk("R2 broadcast ch0", 32'(dac_code[0 +: RW]), 32'h3FFF);
    chk("R2 broadcast ch1", 32'(dac_code[RW +: RW]), 32'h3FFF);

    // R2 unused address
    w24(24'h05_0000, "R8 sdo");
    pulse(1, 0);
    chk("R2 unused address", 32'(dac_code[0 +: RW]), 32'h3FFF);

    // R3 range and power
    w24(24'h09_0004, "R8 sdo");
    chk("R3 range ch1", 32'(out_range[5:3]), 32'h4);
    chk("R3 range ch0 untouched", 32'(out_range[2:0]), 32'h0);
    w24(24'h10_0002, "R8 sdo");
    chk("R3 power word", 32'(ch_power), 32'h2);
    w24(24'h18_FFFF, "R8 sdo");
    chk("R3 nop power", 32'(ch_power), 32'h2);
    chk("R3 nop range", 32'(out_range), 32'h20);

    // R5 reserved bit, short frame, long frame
    w24(24'h50_0003, "R8 sdo");
    chk("R5 reserved dropped", 32'(ch_power), 32'h2);
    frame(48'h0_0000_0003, 20, "R8 sdo", cap);
    chk("R5 short frame dropped", 32'(ch_power), 32'h2);
    frame(48'h1_0000_0003, 25, "R8 sdo", cap);
    chk("R5 25-bit frame dropped", 32'(ch_power), 32'h2);

    // R8 daisy-chain: 48 clocks, second word latched, first word passed on
    frame({24'h00_5A5C, 24'h01_8004}, 48, "R8 sdo", cap);
    chk("R8 passed-on word", 32'(cap[23:0]), 32'h005A5C);
    pulse(1, 0);
    chk("R8 latched word ch1", 32'(dac_code[RW +: RW]), 32'h2001);
    chk("R5 first word not applied", 32'(dac_code[0 +: RW]), 32'h3FFF);

    // R9 readback of a range code, then of an input code
    w24(24'h89_0000, "R8 sdo");
    chk("R9 read writes nothing", 32'(out_range[5:3]), 32'h4);
    frame({24'h0, 24'h18_0000}, 24, "R9 readback bit", cap);
    chk("R9 range readback", 32'(cap[23:0]), 32'h000004);
    w24(24'h80_0000, "R8 sdo");
    frame({24'h0, 24'h18_0000}, 24, "R9 readback bit", cap);
    chk("R9 input readback", 32'(cap[23:0]), 32'h00FFFC);

    // R10 clocks while deselected
    prev = m_sr;
    @(negedge clk);
    ser_din = 1'b1;
    for (int k = 0; k < 5; k++) begin
      ser_clk = 1'b0;
      repeat (2) @(negedge clk);
      ser_clk = 1'b1;
      repeat (2) @(negedge clk);
    end
    chk("R10 sdo while idle", 32'(ser_dout), 32'(m_sdo));
    frame({24'h0, 24'h18_0000}, 24, "R10 sdo", cap);
    chk("R10 shift register frozen", 32'(cap[23:0]), 32'(prev));

    // R7 clear, restore via load, clear beats load
    coding_sel = 1'b1;
    pulse(0, 1);
    chk("R7 clear offset binary ch0", 32'(dac_code[0 +: RW]), 32'h2000);
    chk("R7 clear offset binary ch1", 32'(dac_code[RW +: RW]), 32'h2000);
    pulse(1, 0);
    chk("R7 inputs kept", 32'(dac_code[0 +: RW]), 32'h3FFF);
    coding_sel = 1'b0;
    pulse(1, 1);
    chk("R7 clear over load", 32'(dac_code), 32'h0);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule